// File: doc/BRIEF.md
# Supervisor Reset Controller with Bus-Start Watchdog

This block generates the active-low reset for a microcontroller. It merges three causes into a single output: the power-up reset, a brown-out, and an expired watchdog. A brown-out is reported by a synchronous "supply good" flag that comes from an external comparator. The output stays low while any cause is present. Once every cause has gone, it stays low for a further fixed release delay. That delay is given in milliseconds and converted to clock cycles through a cycles-per-millisecond parameter.

The watchdog has no kick pin of its own. It watches the two lines of a 2-wire serial bus and restarts its count on each bus start condition, which is the data line falling while the clock line is high. The block is configured through plain input pins:

- an enable for the watchdog;
- a 2-bit period select that chooses one of four parameterized timeouts.

A data line that stays high or stays low produces no start condition, so a stuck bus lets the watchdog expire.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst` is high, `cpu_rst_n` is 0. After `rst` falls, with `supply_ok` held high, `cpu_rst_n` becomes 1 at the HOLD_CYC-th rising edge that has `rst` low, where HOLD_CYC = HOLD_MS*CYC_PER_MS.
- R2: `supply_ok` sampled low at a rising edge drives `cpu_rst_n` to 0 at that edge.
- R3: After a brown-out, `cpu_rst_n` returns to 1 only after HOLD_CYC consecutive edges with `supply_ok` high. A new low sample restarts the whole delay.
- R4: A start condition restarts the watchdog count. The start condition is `sda` going from 1 to 0 while `scl` is 1, both seen through a two-flop synchronizer. The restart takes effect at the third rising edge after `sda` changes at the pins.
- R5: With `wd_en` high and no start condition, `cpu_rst_n` falls exactly L edges after it rose. L = WD_MSn*CYC_PER_MS, where n is the value of `wd_sel` (0, 1, 2 or 3 selects WD_MS0, WD_MS1, WD_MS2 or WD_MS3).
- R6: An `sda` fall while `scl` is 0 is not a start condition. Neither is an `sda` line held at a constant level. Neither one restarts the watchdog.
- R7: A watchdog expiry holds `cpu_rst_n` low for HOLD_CYC edges. The watchdog stays idle while the output is low, and a full period starts again after release.
- R8: While `wd_en` is low, the watchdog never asserts reset and its count is cleared. After re-enabling, the full period L applies.
- R9: If `wd_sel` switches to a shorter period after the count has already passed it, the watchdog expires at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| supply_ok | input | 1 | Supply above threshold (1) or below (0), synchronous |
| scl | input | 1 | Serial bus clock line (asynchronous) |
| sda | input | 1 | Serial bus data line (asynchronous) |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Watchdog period select, 0 to 3 |
| cpu_rst_n | output | 1 | Combined active-low reset |

## Verification
Directed patterns separate the three reset causes.

- A clean power-up and a one-cycle supply dip measure the release delay.
- An idle bus measures each of the four watchdog periods.
- Periodic true start conditions must keep the output high indefinitely.
- Data-line falls made only while the clock line is low must not. This pattern separates proper qualification by the clock line from plain edge detection.
- A disable/re-enable sequence and a switch to a shorter period after the count has passed it exercise the count clearing and the late-select corner case.

A long random phase mixes bus activity, supply dips, enable toggles and period changes. It compares the output on every cycle against a bench model of the requirements.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    localparam bus_t BUS_IDLE = '{scl: 1'b1, sda: 1'b1};

    function automatic int unsigned ms_to_cyc(input int unsigned ms, input int unsigned cpm);
        return ms * cpm;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sup_bus_sync.sv
module sup_bus_sync
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic kick
);
    bus_t stage1, stage2;
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= BUS_IDLE;
            stage2   <= BUS_IDLE;
            sda_prev <= 1'b1;
        end else begin
            stage1   <= '{scl: scl, sda: sda};
            stage2   <= stage1;
            sda_prev <= stage2.sda;
        end
    end

    // start condition: data line fell while clock line high
    assign kick = stage2.scl & sda_prev & ~stage2.sda;

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int unsigned LIM0 = 8,
    parameter int unsigned LIM1 = 16,
    parameter int unsigned LIM2 = 24,
    parameter int unsigned LIM3 = 36,
    localparam int unsigned MAXLIM = sup_pkg::max4(LIM0, LIM1, LIM2, LIM3),
    localparam int CW = $clog2(MAXLIM + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       out_high,
    input  logic       kick,
    output logic       fire
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          run;

    always_comb begin
        unique case (wd_sel)
            2'd0:    last = CW'(LIM0 - 1);
            2'd1:    last = CW'(LIM1 - 1);
            2'd2:    last = CW'(LIM2 - 1);
            default: last = CW'(LIM3 - 1);
        endcase
    end

    assign run  = wd_en & out_high;
    assign fire = run & ~kick & (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !run || kick || fire) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    a_r4_kick_clears: assert property (@(posedge clk) disable iff (rst)
        kick |=> cnt == '0);
    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> cnt == '0);
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(MAXLIM));

endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
    parameter int unsigned HOLD_CYC = 12,
    localparam int HW = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic fire,
    output logic out_high
);
    logic [HW-1:0] hc;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok || fire) begin
            out_high <= 1'b0;
            hc       <= '0;
        end else if (!out_high) begin
            if (hc == HW'(HOLD_CYC - 1)) begin
                out_high <= 1'b1;
                hc       <= '0;
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end

    a_r2_low_supply: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !out_high);
    a_r3_release_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(out_high) |-> $past(supply_ok) && !$past(fire));

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 100000,
    parameter int unsigned HOLD_MS    = 200,
    parameter int unsigned WD_MS0     = 25,
    parameter int unsigned WD_MS1     = 200,
    parameter int unsigned WD_MS2     = 1400,
    parameter int unsigned WD_MS3     = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       scl,
    input  logic       sda,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       cpu_rst_n
);
    localparam int unsigned HOLD_CYC = ms_to_cyc(HOLD_MS, CYC_PER_MS);

    logic kick, fire;

    sup_bus_sync u_sync (
        .clk (clk),
        .rst (rst),
        .scl (scl),
        .sda (sda),
        .kick(kick)
    );

    sup_wdog #(
        .LIM0(ms_to_cyc(WD_MS0, CYC_PER_MS)),
        .LIM1(ms_to_cyc(WD_MS1, CYC_PER_MS)),
        .LIM2(ms_to_cyc(WD_MS2, CYC_PER_MS)),
        .LIM3(ms_to_cyc(WD_MS3, CYC_PER_MS))
    ) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .wd_en   (wd_en),
        .wd_sel  (wd_sel),
        .out_high(cpu_rst_n),
        .kick    (kick),
        .fire    (fire)
    );

    sup_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .supply_ok(supply_ok),
        .fire     (fire),
        .out_high (cpu_rst_n)
    );

    // R6/R8: with a good supply, a falling output needs an enabled watchdog
    a_r8_wd_needs_en: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst_n) && $past(supply_ok) |-> $past(wd_en));

endmodule

// File: tb/tb_sup_reset_ctrl.sv
module tb_sup_reset_ctrl;
    localparam int CPM  = 4;
    localparam int HOLD = 3 * CPM;
    localparam int L0 = 2 * CPM, L1 = 4 * CPM, L2 = 6 * CPM, L3 = 9 * CPM;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, supply_ok = 1'b1, scl = 1'b1, sda = 1'b1, wd_en = 1'b0;
    logic [1:0] wd_sel = 2'd0;
    logic cpu_rst_n;

    sup_reset_ctrl #(.CYC_PER_MS(CPM), .HOLD_MS(3), .WD_MS0(2), .WD_MS1(4),
                     .WD_MS2(6), .WD_MS3(9)) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .scl(scl), .sda(sda),
        .wd_en(wd_en), .wd_sel(wd_sel), .cpu_rst_n(cpu_rst_n));

    int checks = 0, fails = 0;
    string tag = "R1";
    logic b_rst = 1, b_ok = 1, b_scl = 1, b_sda = 1, b_en = 0;
    logic [1:0] b_sel = 0;

    // requirement model
    logic m_rn = 0, m_s1c = 1, m_s1d = 1, m_s2c = 1, m_s2d = 1, m_dd = 1;
    int m_wc = 0, m_hc = 0;

    function automatic int f_lim(input logic [1:0] s);
        case (s)
            2'd0: return L0;
            2'd1: return L1;
            2'd2: return L2;
            default: return L3;
        endcase
    endfunction

    task automatic model_step;
        logic k, f;
        int nwc;
        if (b_rst) begin
            m_rn = 0; m_hc = 0; m_wc = 0;
            m_s1c = 1; m_s1d = 1; m_s2c = 1; m_s2d = 1; m_dd = 1;
        end else begin
            k = m_s2c && m_dd && !m_s2d;
            f = b_en && m_rn && !k && (m_wc >= f_lim(b_sel) - 1);
            nwc = (!b_en || !m_rn || k || f) ? 0 : m_wc + 1;
            if (!b_ok || f) begin m_rn = 0; m_hc = 0; end
            else if (!m_rn) begin
                if (m_hc == HOLD - 1) begin m_rn = 1; m_hc = 0; end
                else m_hc++;
            end
            m_dd = m_s2d; m_s2c = m_s1c; m_s2d = m_s1d; m_s1c = b_scl; m_s1d = b_sda;
            m_wc = nwc;
        end
    endtask

    task automatic chk(input string t, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        rst = b_rst; supply_ok = b_ok; scl = b_scl; sda = b_sda;
        wd_en = b_en; wd_sel = b_sel;
        model_step();
        @(posedge clk);
        #1;
        chk({tag, " model"}, int'(cpu_rst_n), int'(m_rn));
    endtask

    task automatic count_until(input logic v, output int n);
        n = 0;
        do begin tick(); n++; end while (cpu_rst_n !== v && n < 200);
    endtask

    task automatic bus(input logic c, input logic d, input int n);
        b_scl = c; b_sda = d;
        repeat (n) tick();
    endtask

    task automatic start_cond;
        bus(1, 1, 1); bus(1, 0, 1); bus(0, 0, 1); bus(0, 1, 1); bus(1, 1, 1);
    endtask

    bit done = 0;
    int n;

    initial begin
        // R1: power-up
        tag = "R1";
        repeat (3) tick();
        chk("R1 reset state", int'(cpu_rst_n), 0);
        b_rst = 0;
        count_until(1, n);
        chk("R1 power-up delay", n, HOLD);

        // R8: disabled watchdog ignores an idle bus
        tag = "R8";
        repeat (3 * L3) tick();
        chk("R8 disabled stays high", int'(cpu_rst_n), 1);

        // R5 / R7: period per select, then hold
        for (int s = 0; s < 4; s++) begin
            tag = "R5";
            b_sel = 2'(s); b_en = 1;
            count_until(0, n);
            if (s == 0) chk("R5 first period sel0", n, L0);
            tag = "R7";
            count_until(1, n);
            chk("R7 wd hold", n, HOLD);
            tag = "R5";
            count_until(0, n);
            chk($sformatf("R5 period sel%0d", s), n, f_lim(2'(s)));
            b_en = 0;
            count_until(1, n);
        end

        // R4: periodic start conditions keep output high
        tag = "R4";
        b_sel = 1; b_en = 1;
        repeat (20) begin start_cond(); bus(1, 1, 5); end
        chk("R4 kicked stays high", int'(cpu_rst_n), 1);

        // R6: sda falls while scl low only
        tag = "R6";
        n = 0;
        while (cpu_rst_n === 1'b1 && n < 100) begin
            bus(0, 1, 1); bus(0, 0, 1); n += 2;
        end
        chk("R6 scl-low fall no kick", int'(cpu_rst_n), 0);
        b_scl = 1; b_sda = 0;
        count_until(1, n);
        count_until(0, n);
        chk("R6 sda stuck low expires", n, L1);
        count_until(1, n);

        // R8: disable clears count
        tag = "R8";
        repeat (10) tick();
        b_en = 0; repeat (3) tick();
        b_en = 1;
        count_until(0, n);
        chk("R8 re-enable full period", n, L1);
        b_en = 0; count_until(1, n);

        // R2 / R3: brown-out
        tag = "R2";
        b_ok = 0; tick();
        chk("R2 supply low asserts", int'(cpu_rst_n), 0);
        b_ok = 1;
        tag = "R3";
        repeat (HOLD - 2) tick();
        b_ok = 0; tick(); b_ok = 1;
        count_until(1, n);
        chk("R3 dip restarts delay", n, HOLD);

        // R9: shorter period after count passed it
        tag = "R9";
        b_sel = 3; b_en = 1;
        repeat (20) tick();
        b_sel = 0; tick();
        chk("R9 late select fires", int'(cpu_rst_n), 0);
        b_en = 0; count_until(1, n);

        // random phase
        tag = "RND R2 R4 R5";
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            b_scl = ($urandom % 4) != 0;
            if ($urandom % 3 == 0) b_sda = ~b_sda;
            b_ok = ($urandom % 60) != 0;
            if ($urandom % 150 == 0) b_en = ~b_en;
            if ($urandom % 200 == 0) b_sel = 2'($urandom);
            if (i % 500 < 60) b_sda = 1;
            tick();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule